// File: doc/BRIEF.md
# PHY Management Register Bridge

This block gives a host a small byte-wide register window onto the management registers of an external Ethernet PHY. The host picks a PHY register number, then either loads a 16-bit value as two bytes (the write goes out when the upper byte lands) or raises a read command bit. The bridge then clocks a single management frame out on the serial clock and data pins. While the frame is on the wire the host sees a busy flag. After a read, the returned 16-bit value sits in two readable byte registers.

One fixed PHY address is used, set by a parameter. The serial clock comes from the system clock through a divider that is also a parameter. Continuous scanning is not supported: its command bit is accepted and discarded, and the matching status flag always reads zero.

Host register map (3-bit address): 0 register select (bits 4:0), 1 write data low byte, 2 write data high byte, 3 command (bit 0 = read request, bit 1 = scan request, never stored), 4 status (bit 0 = busy, bit 2 = invalid-scan flag, always 0), 5 read result low byte, 6 read result high byte. Reads of any other address return 0.

Top module: `mdio_mgmt_bridge`

## Requirements
- R1: After reset, status, command, both read-result bytes and both write-data bytes read 0; the serial clock is low and the data pin is not driven.
- R2: A write frame is sent MSB first as PRE_LEN ones, start bits 01, opcode 01, the 5-bit PHY address, the 5-bit register select, turnaround 10, then the 16 data bits {high byte, low byte}.
- R3: Writing address 1 (low data byte) alone starts nothing; writing address 2 (high data byte) while idle starts a write frame, and busy reads 1 from the next cycle.
- R4: Status bit 0 stays 1 for exactly (PRE_LEN+32)*2*MDC_HALF clock cycles per frame and then returns to 0.
- R5: Writing a 1 into command bit 0 while it holds 0 and the bridge is idle starts a read frame with opcode 10; the bridge stops driving the data pin for the two turnaround bits and the 16 data bits, and samples the data pin on each rising serial-clock edge.
- R6: When a read frame completes, the 16 bits sampled MSB first appear as {address 6, address 5}.
- R7: Command bit 0 stays 1 until the host writes it to 0; writing 1 again while it already holds 1 starts no frame.
- R8: Any host write made while busy is 1 has no effect: register contents read back unchanged and no extra frame is sent.
- R9: While idle the serial clock is low and the data pin is released; during a frame each serial-clock period is 2*MDC_HALF system cycles.
- R10: Writing command bit 1 (scan) starts no frame and reads back as 0; status bit 2 always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host write strobe, one cycle per byte |
| hostAddr | input | 3 | Host write register address |
| hostWrData | input | 8 | Host write byte |
| hostRdAddr | input | 3 | Host read register address |
| hostRdData | output | 8 | Host read byte, combinational from hostRdAddr |
| mdc | output | 1 | Management serial clock |
| mdioOut | output | 1 | Management data driven by the bridge |
| mdioOe | output | 1 | Output enable for mdioOut |
| mdioIn | input | 1 | Management data seen on the pin |

## Verification
The bench builds the bridge with MDC_HALF = 2, the full 32-bit preamble and PHY address 0x11. This makes each frame 256 system cycles long, so a run fits several writes, two reads, a write collision and a scan request, and the exact busy length and serial-clock period can be counted cycle by cycle. A nonzero PHY address with mixed bit values shows whether the address field is placed and ordered correctly, and the read values 0xBEEF and 0x8001 catch byte swaps and lost end bits in the result.

// File: rtl/mdio_bridge_pkg.sv
package mdio_bridge_pkg;
  localparam int HOST_AW = 3;

  localparam logic [HOST_AW-1:0] ADDR_REG_SEL  = 3'd0;
  localparam logic [HOST_AW-1:0] ADDR_WDATA_LO = 3'd1;
  localparam logic [HOST_AW-1:0] ADDR_WDATA_HI = 3'd2;
  localparam logic [HOST_AW-1:0] ADDR_CMD      = 3'd3;
  localparam logic [HOST_AW-1:0] ADDR_STATUS   = 3'd4;
  localparam logic [HOST_AW-1:0] ADDR_RDATA_LO = 3'd5;
  localparam logic [HOST_AW-1:0] ADDR_RDATA_HI = 3'd6;

  // start(2) + opcode(2) + phy(5) + register(5)
  localparam int HDR_BITS  = 14;
  localparam int TA_BITS   = 2;
  localparam int DATA_BITS = 16;

  // control -> datapath strobes
  typedef struct packed {
    logic load;    // build a new frame
    logic shift;   // advance to next outgoing bit
    logic sample;  // capture mdioIn
    logic done;    // frame finished
  } mdioStrobes_t;
endpackage

// File: rtl/mdio_bridge_ctrl.sv
module mdio_bridge_ctrl
  import mdio_bridge_pkg::*;
#(
  parameter int MDC_HALF = 10,
  parameter int PRE_LEN  = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startReq,
  input  logic         opIsRead,
  output mdioStrobes_t strobes,
  output logic         busy,
  output logic         mdc,
  output logic         mdioOe
);
  localparam int FRAME_LEN   = PRE_LEN + HDR_BITS + TA_BITS + DATA_BITS;
  localparam int IDX_W       = $clog2(FRAME_LEN);
  localparam int DIV_W       = $clog2(MDC_HALF) + 1;
  localparam int RELEASE_IDX = PRE_LEN + HDR_BITS;
  localparam int DATA_IDX    = RELEASE_IDX + TA_BITS;

  typedef enum logic {S_IDLE, S_RUN} state_t;

  state_t           state;
  logic [DIV_W-1:0] divCnt;
  logic [IDX_W-1:0] bitIdx;
  logic             halfTick;
  logic             lastBit;

  assign halfTick = (divCnt == DIV_W'(MDC_HALF - 1));
  assign lastBit  = (bitIdx == IDX_W'(FRAME_LEN - 1));
  assign busy     = (state == S_RUN);
  assign mdioOe   = busy && !(opIsRead && (bitIdx >= IDX_W'(RELEASE_IDX)));

  always_comb begin
    strobes = '0;
    strobes.load = (state == S_IDLE) && startReq;
    if (state == S_RUN && halfTick) begin
      if (!mdc) begin
        strobes.sample = opIsRead && (bitIdx >= IDX_W'(DATA_IDX));
      end else if (lastBit) begin
        strobes.done = 1'b1;
      end else begin
        strobes.shift = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      divCnt <= '0;
      bitIdx <= '0;
      mdc    <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (startReq) begin
            state  <= S_RUN;
            divCnt <= '0;
            bitIdx <= '0;
            mdc    <= 1'b0;
          end
        end
        default: begin
          divCnt <= halfTick ? '0 : divCnt + 1'b1;
          if (halfTick) begin
            mdc <= !mdc;
            if (mdc) begin
              if (lastBit) state <= S_IDLE;
              else         bitIdx <= bitIdx + 1'b1;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/mdio_bridge_datapath.sv
module mdio_bridge_datapath
  import mdio_bridge_pkg::*;
#(
  parameter logic [4:0] PHY_ADDR = 5'h01,
  parameter int         PRE_LEN  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostWrEn,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [7:0]         hostWrData,
  input  logic [HOST_AW-1:0] hostRdAddr,
  output logic [7:0]         hostRdData,
  input  logic               busy,
  input  mdioStrobes_t       strobes,
  input  logic               mdioIn,
  output logic               startReq,
  output logic               opIsRead,
  output logic               mdioOut
);
  localparam int FRAME_LEN = PRE_LEN + HDR_BITS + TA_BITS + DATA_BITS;

  logic [4:0]           regSel;
  logic [7:0]           wrLo;
  logic [7:0]           wrHi;
  logic                 cmdRead;
  logic [15:0]          rdData;
  logic [15:0]          capture;
  logic [FRAME_LEN-1:0] frameSr;
  logic                 wrAccept;
  logic                 startWrite;
  logic                 startRead;
  logic [FRAME_LEN-1:0] newFrame;

  assign wrAccept   = hostWrEn && !busy;
  assign startWrite = wrAccept && (hostAddr == ADDR_WDATA_HI);
  assign startRead  = wrAccept && (hostAddr == ADDR_CMD) && hostWrData[0] && !cmdRead;
  assign startReq   = startWrite || startRead;
  assign mdioOut    = frameSr[FRAME_LEN-1];

  always_comb begin
    if (startRead)
      newFrame = {{PRE_LEN{1'b1}}, 2'b01, 2'b10, PHY_ADDR, regSel, 2'b11, 16'hFFFF};
    else
      newFrame = {{PRE_LEN{1'b1}}, 2'b01, 2'b01, PHY_ADDR, regSel, 2'b10, hostWrData, wrLo};
  end

  // host-visible registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      regSel  <= '0;
      wrLo    <= '0;
      wrHi    <= '0;
      cmdRead <= 1'b0;
    end else if (wrAccept) begin
      case (hostAddr)
        ADDR_REG_SEL:  regSel  <= hostWrData[4:0];
        ADDR_WDATA_LO: wrLo    <= hostWrData;
        ADDR_WDATA_HI: wrHi    <= hostWrData;
        ADDR_CMD:      cmdRead <= hostWrData[0];
        default: ;
      endcase
    end
  end

  // frame shifter and read capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameSr  <= '0;
      capture  <= '0;
      rdData   <= '0;
      opIsRead <= 1'b0;
    end else begin
      if (strobes.load) begin
        frameSr  <= newFrame;
        capture  <= '0;
        opIsRead <= startRead;
      end else if (strobes.shift) begin
        frameSr <= {frameSr[FRAME_LEN-2:0], 1'b1};
      end
      if (strobes.sample) capture <= {capture[14:0], mdioIn};
      if (strobes.done && opIsRead) rdData <= capture;
    end
  end

  always_comb begin
    case (hostRdAddr)
      ADDR_REG_SEL:  hostRdData = {3'b000, regSel};
      ADDR_WDATA_LO: hostRdData = wrLo;
      ADDR_WDATA_HI: hostRdData = wrHi;
      ADDR_CMD:      hostRdData = {7'b0, cmdRead};
      ADDR_STATUS:   hostRdData = {7'b0, busy};
      ADDR_RDATA_LO: hostRdData = rdData[7:0];
      ADDR_RDATA_HI: hostRdData = rdData[15:8];
      default:       hostRdData = 8'h00;
    endcase
  end
endmodule

// File: rtl/mdio_mgmt_bridge.sv
module mdio_mgmt_bridge
  import mdio_bridge_pkg::*;
#(
  parameter logic [4:0] PHY_ADDR = 5'h01,
  parameter int         MDC_HALF = 10,
  parameter int         PRE_LEN  = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         hostWrEn,
  input  logic [2:0]   hostAddr,
  input  logic [7:0]   hostWrData,
  input  logic [2:0]   hostRdAddr,
  output logic [7:0]   hostRdData,
  output logic         mdc,
  output logic         mdioOut,
  output logic         mdioOe,
  input  logic         mdioIn
);
  mdioStrobes_t strobes;
  logic         busy;
  logic         startReq;
  logic         opIsRead;

  mdio_bridge_ctrl #(
    .MDC_HALF (MDC_HALF),
    .PRE_LEN  (PRE_LEN)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .opIsRead (opIsRead),
    .strobes  (strobes),
    .busy     (busy),
    .mdc      (mdc),
    .mdioOe   (mdioOe)
  );

  mdio_bridge_datapath #(
    .PHY_ADDR (PHY_ADDR),
    .PRE_LEN  (PRE_LEN)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .hostWrEn   (hostWrEn),
    .hostAddr   (hostAddr),
    .hostWrData (hostWrData),
    .hostRdAddr (hostRdAddr),
    .hostRdData (hostRdData),
    .busy       (busy),
    .strobes    (strobes),
    .mdioIn     (mdioIn),
    .startReq   (startReq),
    .opIsRead   (opIsRead),
    .mdioOut    (mdioOut)
  );
endmodule

// File: rtl/mdio_bridge_checker.sv
module mdio_bridge_checker
  import mdio_bridge_pkg::*;
(
  input logic         clk,
  input logic         rstN,
  input logic         hostWrEn,
  input logic [2:0]   hostAddr,
  input logic         busy,
  input logic         mdc,
  input logic         mdioOe,
  input mdioStrobes_t strobes
);
  p_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && hostAddr == ADDR_WDATA_HI && !busy) |=> busy);

  p_busy_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strobes.done) |=> busy);

  p_done_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.done |=> !busy);

  p_sample_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.sample |-> !mdc);

  p_sample_rise_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.sample |=> mdc);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!mdc && !mdioOe));
endmodule

bind mdio_mgmt_bridge mdio_bridge_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .hostWrEn (hostWrEn),
  .hostAddr (hostAddr),
  .busy     (busy),
  .mdc      (mdc),
  .mdioOe   (mdioOe),
  .strobes  (strobes)
);

// File: tb/tb_mdio_mgmt_bridge.sv
`timescale 1ns/1ps
module tb_mdio_mgmt_bridge;
  localparam logic [4:0] PHY = 5'h11;
  localparam int HALF = 2;
  localparam int PRE = 32;
  localparam int FLEN = PRE + 32;
  localparam int BUSY_CYCLES = FLEN * 2 * HALF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostWrEn = 1'b0;
  logic [2:0] hostAddr = '0;
  logic [7:0] hostWrData = '0;
  logic [2:0] hostRdAddr = '0;
  logic [7:0] hostRdData;
  logic mdc, mdioOut, mdioOe;
  logic mdioIn = 1'b1;

  int checks = 0;
  int failures = 0;
  int framesSeen = 0;
  logic [21:0] expQ[$];        // {isRead, register, data}
  logic [15:0] phyResp = '0;
  logic [63:0] frameBits = '0;
  int bitPos = 0;
  bit releaseBad = 0;
  bit periodBad = 0;
  longint cycle = 0;
  longint lastRise = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cycle <= cycle + 1;

  mdio_mgmt_bridge #(.PHY_ADDR(PHY), .MDC_HALF(HALF), .PRE_LEN(PRE)) dut (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdAddr(hostRdAddr), .hostRdData(hostRdData),
    .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    hostWrEn = 1'b1; hostAddr = a; hostWrData = d;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic hostRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    hostRdAddr = a;
    #1 d = hostRdData;
  endtask

  task automatic waitIdle();
    hostRdAddr = 3'd4;
    #1;
    for (int i = 0; i < 2000 && hostRdData[0]; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  // PHY monitor: scoreboard comparison at the end of each frame
  always @(posedge mdc) begin
    if (bitPos > 0 && (cycle - lastRise) != 2 * HALF) periodBad = 1;
    lastRise = cycle;
    frameBits[63 - bitPos] = mdioOe ? mdioOut : mdioIn;
    if (bitPos >= 46 && frameBits[29:28] == 2'b10 && mdioOe) releaseBad = 1;
    if (bitPos == 63) begin
      logic [21:0] got;
      logic [21:0] exp;
      framesSeen++;
      got = {frameBits[29:28] == 2'b10, frameBits[22:18], frameBits[15:0]};
      if (expQ.size() == 0) begin
        check(0, "R8 unexpected frame", got, 0);
      end else begin
        exp = expQ.pop_front();
        check(got == exp, "R2/R5 frame content", got, exp);
        check(frameBits[63:32] == '1 && frameBits[31:30] == 2'b01 && frameBits[27:23] == PHY,
              "R2 preamble/start/phy", frameBits[63:23], {32'hFFFFFFFF, 2'b01, 2'b00, PHY});
        if (exp[21]) begin
          check(frameBits[29:28] == 2'b10 && !releaseBad, "R5 read opcode and bus release",
                {frameBits[29:28], releaseBad}, 3'b100);
        end else begin
          check(frameBits[29:28] == 2'b01 && frameBits[17:16] == 2'b10,
                "R2 write opcode and turnaround", {frameBits[29:28], frameBits[17:16]}, 4'b0110);
        end
      end
      releaseBad = 0;
      bitPos = 0;
    end else begin
      bitPos = bitPos + 1;
    end
  end

  // PHY responder: drives read data after the falling edge
  always @(negedge mdc) begin
    if (frameBits[29:28] == 2'b10 && bitPos >= 48)
      mdioIn = phyResp[15 - (bitPos - 48)];
    else
      mdioIn = 1'b1;
  end

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #1_500_000;
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    finishRun();
  end

  initial begin
    logic [7:0] d;
    int cnt;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      hostRead(3'(a), d);
      check(d == 8'h00, "R1 register reset value", d, 0);
    end
    check(!mdc && !mdioOe, "R1/R9 idle pins", {mdc, mdioOe}, 0);

    // R3 low byte alone does nothing
    hostWrite(3'd0, 8'h05);
    hostWrite(3'd1, 8'h34);
    hostRead(3'd4, d);
    check(d[0] == 1'b0, "R3 low byte does not start", d, 0);

    // R3/R4 high byte starts, count busy length
    expQ.push_back({1'b0, 5'h05, 16'h1234});
    hostWrite(3'd2, 8'h12);
    hostRdAddr = 3'd4;
    #1;
    check(hostRdData[0] == 1'b1, "R3 busy after high byte", hostRdData, 1);
    cnt = 0;
    while (hostRdData[0] && cnt < 5000) begin
      cnt++;
      @(negedge clk);
      #1;
    end
    check(cnt == BUSY_CYCLES, "R4 busy length", cnt, BUSY_CYCLES);

    // R2 second write with other pattern
    hostWrite(3'd0, 8'h1F);
    hostWrite(3'd1, 8'hC3);
    expQ.push_back({1'b0, 5'h1F, 16'hA5C3});
    hostWrite(3'd2, 8'hA5);
    waitIdle();

    // R5/R6/R7 read
    phyResp = 16'hBEEF;
    hostWrite(3'd0, 8'h02);
    expQ.push_back({1'b1, 5'h02, 16'hBEEF});
    hostWrite(3'd3, 8'h01);
    waitIdle();
    hostRead(3'd3, d);
    check(d[0] == 1'b1, "R7 command bit held after read", d, 1);
    hostWrite(3'd3, 8'h01);
    hostRead(3'd4, d);
    check(d[0] == 1'b0, "R7 rewriting set bit starts nothing", d, 0);
    hostWrite(3'd3, 8'h00);
    hostRead(3'd5, d);
    check(d == 8'hEF, "R6 read result low byte", d, 8'hEF);
    hostRead(3'd6, d);
    check(d == 8'hBE, "R6 read result high byte", d, 8'hBE);

    // R8 writes while busy ignored
    hostWrite(3'd0, 8'h03);
    hostWrite(3'd1, 8'h0F);
    expQ.push_back({1'b0, 5'h03, 16'h0F0F});
    hostWrite(3'd2, 8'h0F);
    hostWrite(3'd2, 8'h77);
    hostWrite(3'd1, 8'h66);
    hostWrite(3'd3, 8'h01);
    hostWrite(3'd0, 8'h09);
    waitIdle();
    repeat (4) @(negedge clk);
    hostRead(3'd2, d);
    check(d == 8'h0F, "R8 high byte unchanged", d, 8'h0F);
    hostRead(3'd1, d);
    check(d == 8'h0F, "R8 low byte unchanged", d, 8'h0F);
    hostRead(3'd3, d);
    check(d == 8'h00, "R8 command unchanged", d, 0);
    hostRead(3'd0, d);
    check(d == 8'h03, "R8 register select unchanged", d, 3);
    hostRead(3'd4, d);
    check(d[0] == 1'b0, "R8 no extra frame started", d, 0);

    // R10 scan request ignored
    hostWrite(3'd3, 8'h02);
    hostRead(3'd4, d);
    check(d == 8'h00, "R10 no frame and invalid flag clear", d, 0);
    hostRead(3'd3, d);
    check(d == 8'h00, "R10 scan bit reads 0", d, 0);

    // R6 boundary bits
    phyResp = 16'h8001;
    hostWrite(3'd0, 8'h1E);
    expQ.push_back({1'b1, 5'h1E, 16'h8001});
    hostWrite(3'd3, 8'h01);
    waitIdle();
    hostWrite(3'd3, 8'h00);
    hostRead(3'd5, d);
    check(d == 8'h01, "R6 end bit low byte", d, 8'h01);
    hostRead(3'd6, d);
    check(d == 8'h80, "R6 end bit high byte", d, 8'h80);

    repeat (10) @(negedge clk);
    check(!periodBad, "R9 serial clock period", periodBad, 0);
    check(framesSeen == 5, "R8 frame count", framesSeen, 5);
    check(expQ.size() == 0, "R2 scoreboard drained", expQ.size(), 0);
    check(!mdc && !mdioOe, "R9 idle pins after traffic", {mdc, mdioOe}, 0);
    finishRun();
  end
endmodule